// File: doc/BRIEF.md
# Fixed-Point Time-Multiplexed Matrix-Vector Multiplier

This block computes y = M·x. The weight matrix M sits in a local synchronous memory, and the input vector x is captured into a register file when a run starts. The arithmetic is done by a small bank of multiply-accumulate lanes that is reused over many clock cycles. Each cycle, one memory word brings in as many weights as there are lanes. Those weights are multiplied by the matching vector elements, and the lane products are added into a wide accumulator for the current row.

Weights are signed 16-bit values with 14 fractional bits, and vector elements are signed 16-bit values with 12 fractional bits. Every product therefore carries 26 fractional bits. A row is summed at full precision, then rounded and saturated back into the 12-fraction-bit format of the vector. A client first fills the weight memory through its write port, then presents the row and column counts and the packed vector, and pulses start. The packed result is valid when done pulses, and it stays valid until the next run is accepted. The memory is a behavioural array that stands in for an SRAM macro.

Top module: `mvm_tmul`

## Requirements
- R1: After reset, busy and done are low and every element of vec_out is zero.
- R2: Each weight is a signed Q2.14 value multiplied by a signed Q4.12 vector element. The memory word at address row*(COLS_MAX/LANES)+beat holds, in bits [16k+15:16k], the weight of column beat*LANES+k. Vector element c sits in vec_in bits [16c+15:16c], and row r of the result sits in vec_out bits [16r+15:16r].
- R3: A row is accumulated in a signed accumulator of ACC_W bits (48 by default, at least 40). No precision is lost before the final reduction, and partial sums beyond the 32-bit range do not corrupt the result.
- R4: A row sum is reduced by adding 2^13 and then shifting arithmetically right by 14 (round half up). For example, -1.5 LSB gives -1 and +1.5 LSB gives +2.
- R5: A reduced value outside the signed 16-bit range saturates to 32767 or -32768.
- R6: When the column count is not a multiple of LANES, lanes past the last column contribute zero, whatever the memory word or vec_in holds there.
- R7: A run of R rows and C columns asserts busy from the clock edge that accepts start until done. Done rises exactly R*ceil(C/LANES)+1 clock edges after the accepting edge.
- R8: Done is high for exactly one cycle per accepted run, and busy is low in that cycle.
- R9: An accepted start clears vec_out to zero and captures vec_in. Rows beyond the row count read zero after the run. Between done and the next accepted start, vec_out holds, whatever the values of vec_in, rows_m1 or cols_m1.
- R10: A start pulse while busy is high is ignored. It changes neither the result, the latency nor the captured dimensions.
- R11: The dimensions are given minus one (rows_m1, cols_m1), so every size from 1x1 up to 64x64 can be encoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, taken only when idle |
| rows_m1 | input | log2(ROWS_MAX) | Row count minus one |
| cols_m1 | input | log2(COLS_MAX) | Column count minus one |
| vec_in | input | COLS_MAX*16 | Packed Q4.12 input vector |
| wt_we | input | 1 | Weight memory write enable |
| wt_waddr | input | log2(ROWS_MAX*COLS_MAX/LANES) | Weight memory write address |
| wt_wdata | input | LANES*16 | Weight memory write word (LANES Q2.14 values) |
| vec_out | output | ROWS_MAX*16 | Packed Q4.12 result vector |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions watch the control behaviour on every cycle. They check that done is a single-cycle pulse that ends busy, that a read issued to the memory is followed by a valid beat in the next cycle, that the latched dimensions do not move when start arrives during a run, and that vec_out holds while the block is idle. The numeric behaviour can only be shown by the bench's scenarios. These cover half-LSB rounding in both signs, saturation at both rails, partial sums above 32 bits, masking of unused lanes against deliberately non-zero data, and the exact latency for several matrix shapes up to 64x64. A behavioural model is compared against the design's outputs on every clock.

// File: rtl/mvm_pkg.sv
`timescale 1ns/1ps
package mvm_pkg;
   // element format: 16-bit signed; weights carry 14 fraction bits, vector 12
   localparam int ELEM_W  = 16;
   localparam int W_FRAC  = 14;
   localparam int X_FRAC  = 12;
   localparam int PROD_W  = 2 * ELEM_W;
   localparam int DROP    = W_FRAC;          // product fraction minus output fraction
   localparam int WIDE_W  = 64;
   localparam logic signed [WIDE_W-1:0] HALF    = 64'sd1 <<< (DROP - 1);
   localparam logic signed [WIDE_W-1:0] OUT_MAX = (64'sd1 <<< (ELEM_W - 1)) - 64'sd1;
   localparam logic signed [WIDE_W-1:0] OUT_MIN = -(64'sd1 <<< (ELEM_W - 1));

   typedef struct packed {
      logic vld;
      logic first;
      logic last;
   } beat_tag_t;

   // round half up, then clamp into the signed element range
   function automatic logic signed [ELEM_W-1:0] round_sat(input logic signed [WIDE_W-1:0] a);
      logic signed [WIDE_W-1:0] t;
      t = (a + HALF) >>> DROP;
      if (t > OUT_MAX)      return OUT_MAX[ELEM_W-1:0];
      else if (t < OUT_MIN) return OUT_MIN[ELEM_W-1:0];
      else                  return t[ELEM_W-1:0];
   endfunction
endpackage

// File: rtl/mvm_weight_mem.sv
`timescale 1ns/1ps
module mvm_weight_mem #(
   parameter int DEPTH  = 1024,
   parameter int DATA_W = 64,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/mvm_mac_bank.sv
`timescale 1ns/1ps
module mvm_mac_bank
   import mvm_pkg::*;
#(
   parameter int LANES = 4,
   parameter int ACC_W = 48,
   parameter int BW    = 4,
   parameter int CD_W  = 6,
   localparam int WORD_W = LANES * ELEM_W
) (
   input  logic [WORD_W-1:0]       w_word,
   input  logic [WORD_W-1:0]       x_word,
   input  logic [BW-1:0]           beat,
   input  logic [CD_W-1:0]         ncols_m1,
   output logic signed [ACC_W-1:0] beat_sum
);
   logic signed [PROD_W-1:0] lane_prod [LANES];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic lane_on;
      assign lane_on = (int'(beat) * LANES + k) <= int'(ncols_m1);
      assign lane_prod[k] = lane_on
         ? PROD_W'($signed(w_word[k*ELEM_W +: ELEM_W]) * $signed(x_word[k*ELEM_W +: ELEM_W]))
         : '0;
   end

   always_comb begin
      logic signed [ACC_W-1:0] s;
      s = '0;
      for (int k = 0; k < LANES; k++) s = s + ACC_W'(lane_prod[k]);
      beat_sum = s;
   end
endmodule

// File: rtl/mvm_seq.sv
`timescale 1ns/1ps
module mvm_seq
   import mvm_pkg::*;
#(
   parameter int ROWS_MAX  = 64,
   parameter int BEATS_MAX = 16,
   parameter int LANES     = 4,
   parameter int CD_W      = 6,
   localparam int RW  = $clog2(ROWS_MAX),
   localparam int BW  = $clog2(BEATS_MAX),
   localparam int LSH = $clog2(LANES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [RW-1:0]   rows_m1,
   input  logic [CD_W-1:0] cols_m1,
   output logic            busy,
   output logic            accept,
   output logic            rd_en,
   output logic [RW+BW-1:0] rd_addr,
   output beat_tag_t       tag,
   output logic [RW-1:0]   p_row,
   output logic [BW-1:0]   p_beat,
   output logic [CD_W-1:0] ncols_m1,
   output logic            done
);
   logic          issuing;
   logic [RW-1:0] i_row, nrow_m1;
   logic [BW-1:0] i_beat, nbeat_m1;

   assign accept  = start && !busy;
   assign rd_en   = issuing;
   assign rd_addr = {i_row, i_beat};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         issuing  <= 1'b0;
         done     <= 1'b0;
         i_row    <= '0;
         i_beat   <= '0;
         nrow_m1  <= '0;
         nbeat_m1 <= '0;
         ncols_m1 <= '0;
         tag      <= '0;
         p_row    <= '0;
         p_beat   <= '0;
      end else begin
         done   <= 1'b0;
         tag    <= '{vld: issuing, first: (i_beat == '0), last: (i_beat == nbeat_m1)};
         p_row  <= i_row;
         p_beat <= i_beat;
         if (accept) begin
            busy     <= 1'b1;
            issuing  <= 1'b1;
            i_row    <= '0;
            i_beat   <= '0;
            nrow_m1  <= rows_m1;
            nbeat_m1 <= BW'(cols_m1 >> LSH);
            ncols_m1 <= cols_m1;
         end else if (issuing) begin
            if (i_beat == nbeat_m1) begin
               i_beat <= '0;
               if (i_row == nrow_m1) issuing <= 1'b0;
               else                  i_row   <= i_row + 1'b1;
            end else begin
               i_beat <= i_beat + 1'b1;
            end
         end
         if (tag.vld && tag.last && (p_row == nrow_m1)) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end
   end

   // R8: completion is a single-cycle pulse
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: done marks the cycle right after busy ends
   a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R7: a memory read is followed by a valid beat one cycle later
   a_r7_fill_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> tag.vld);
   // R10: start during a run leaves the captured dimensions alone
   a_r10_busy_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(nrow_m1) && $stable(ncols_m1)));
endmodule

// File: rtl/mvm_tmul.sv
`timescale 1ns/1ps
module mvm_tmul
   import mvm_pkg::*;
#(
   parameter int ROWS_MAX = 64,
   parameter int COLS_MAX = 64,
   parameter int LANES    = 4,
   parameter int ACC_W    = 48,
   localparam int BEATS_MAX = COLS_MAX / LANES,
   localparam int RW        = $clog2(ROWS_MAX),
   localparam int CD_W      = $clog2(COLS_MAX),
   localparam int BW        = $clog2(BEATS_MAX),
   localparam int AW        = RW + BW,
   localparam int WORD_W    = LANES * ELEM_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [RW-1:0]              rows_m1,
   input  logic [CD_W-1:0]            cols_m1,
   input  logic [COLS_MAX*ELEM_W-1:0] vec_in,
   input  logic                       wt_we,
   input  logic [AW-1:0]              wt_waddr,
   input  logic [WORD_W-1:0]          wt_wdata,
   output logic [ROWS_MAX*ELEM_W-1:0] vec_out,
   output logic                       busy,
   output logic                       done
);
   // elaboration-time parameter checks
   if (COLS_MAX % LANES != 0) begin : g_bad_lanes
      $error("COLS_MAX must be a multiple of LANES");
   end
   if ((LANES & (LANES - 1)) != 0 || (BEATS_MAX & (BEATS_MAX - 1)) != 0 || BEATS_MAX < 2) begin : g_bad_beats
      $error("LANES and COLS_MAX/LANES must be powers of two, at least two beats");
   end
   if ((ROWS_MAX & (ROWS_MAX - 1)) != 0 || ROWS_MAX < 2) begin : g_bad_rows
      $error("ROWS_MAX must be a power of two, at least 2");
   end
   if (ACC_W < 40 || ACC_W > WIDE_W - 2) begin : g_bad_acc
      $error("ACC_W must lie between 40 and 62");
   end

   logic                       accept, rd_en;
   logic [AW-1:0]              rd_addr;
   logic [WORD_W-1:0]          rd_data, x_word;
   beat_tag_t                  tag;
   logic [RW-1:0]              p_row;
   logic [BW-1:0]              p_beat;
   logic [CD_W-1:0]            ncols_m1;
   logic [COLS_MAX*ELEM_W-1:0] vec_reg;
   logic signed [ACC_W-1:0]    beat_sum, acc_q, acc_nxt;
   logic signed [ELEM_W-1:0]   out_q [ROWS_MAX];

   mvm_seq #(.ROWS_MAX(ROWS_MAX), .BEATS_MAX(BEATS_MAX), .LANES(LANES), .CD_W(CD_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .rows_m1(rows_m1), .cols_m1(cols_m1),
      .busy(busy), .accept(accept), .rd_en(rd_en), .rd_addr(rd_addr), .tag(tag),
      .p_row(p_row), .p_beat(p_beat), .ncols_m1(ncols_m1), .done(done));

   mvm_weight_mem #(.DEPTH(ROWS_MAX * BEATS_MAX), .DATA_W(WORD_W)) u_mem (
      .clk(clk), .we(wt_we), .waddr(wt_waddr), .wdata(wt_wdata),
      .re(rd_en), .raddr(rd_addr), .rdata(rd_data));

   assign x_word = vec_reg[int'(p_beat) * WORD_W +: WORD_W];

   mvm_mac_bank #(.LANES(LANES), .ACC_W(ACC_W), .BW(BW), .CD_W(CD_W)) u_mac (
      .w_word(rd_data), .x_word(x_word), .beat(p_beat), .ncols_m1(ncols_m1),
      .beat_sum(beat_sum));

   assign acc_nxt = (tag.first ? '0 : acc_q) + beat_sum;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_reg <= '0;
         acc_q   <= '0;
         for (int r = 0; r < ROWS_MAX; r++) out_q[r] <= '0;
      end else if (accept) begin
         vec_reg <= vec_in;
         for (int r = 0; r < ROWS_MAX; r++) out_q[r] <= '0;
      end else if (tag.vld) begin
         acc_q <= acc_nxt;
         if (tag.last) out_q[p_row] <= round_sat(WIDE_W'(acc_nxt));
      end
   end

   for (genvar r = 0; r < ROWS_MAX; r++) begin : g_out
      assign vec_out[r*ELEM_W +: ELEM_W] = out_q[r];
   end

   // R9: results hold while idle and no run is being accepted
   a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(vec_out));
endmodule

// File: tb/tb_mvm_tmul.sv
`timescale 1ns/1ps
module tb_mvm_tmul;
   localparam int ROWS = 64, COLS = 64, L = 4, EW = 16, BEATS = COLS / L;

   logic                 clk = 1'b0, rst_n = 1'b0, start = 1'b0, wt_we = 1'b0;
   logic [5:0]           rows_m1 = '0, cols_m1 = '0;
   logic [COLS*EW-1:0]   vec_in = '0;
   logic [9:0]           wt_waddr = '0;
   logic [L*EW-1:0]      wt_wdata = '0;
   logic [ROWS*EW-1:0]   vec_out;
   logic                 busy, done;

   mvm_tmul dut (.clk(clk), .rst_n(rst_n), .start(start), .rows_m1(rows_m1),
      .cols_m1(cols_m1), .vec_in(vec_in), .wt_we(wt_we), .wt_waddr(wt_waddr),
      .wt_wdata(wt_wdata), .vec_out(vec_out), .busy(busy), .done(done));

   always #5 clk = ~clk;

   int  checks = 0, fails = 0;
   bit  finished = 0, mon_on = 0;
   int  mW [ROWS][COLS];
   int  vx [COLS];
   bit  m_busy = 0, m_done = 0;
   int  m_left = 0;
   int  m_out [ROWS];
   int  m_pend [ROWS];

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int expect_row(int r, int nc);
      longint acc = 0;
      for (int c = 0; c < nc; c++) acc += longint'(mW[r][c]) * longint'(vx[c]);
      acc = (acc + 8192) >>> 14;
      if (acc > 32767) acc = 32767;
      if (acc < -32768) acc = -32768;
      return int'(acc);
   endfunction

   function automatic int out_el(int r);
      return int'($signed(vec_out[r*EW +: EW]));
   endfunction

   // behavioural reference: a countdown per run, results fixed at acceptance
   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_left = 0;
         for (int r = 0; r < ROWS; r++) m_out[r] = 0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
               m_busy = 0; m_done = 1;
               for (int r = 0; r < ROWS; r++) m_out[r] = m_pend[r];
            end
         end else if (start) begin
            for (int r = 0; r < ROWS; r++) begin
               m_out[r] = 0;
               m_pend[r] = (r <= int'(rows_m1)) ? expect_row(r, int'(cols_m1) + 1) : 0;
            end
            m_left = (int'(rows_m1) + 1) * ((int'(cols_m1) + L) / L) + 1;
            m_busy = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && mon_on && !finished) begin
         chk(busy == m_busy, "R7", "busy per cycle", longint'(busy), longint'(m_busy));
         chk(done == m_done, "R8", "done per cycle", longint'(done), longint'(m_done));
         if (!m_busy) begin
            int bad = -1;
            for (int r = 0; r < ROWS; r++) if (out_el(r) != m_out[r]) bad = r;
            chk(bad < 0, "R9", "vec_out vs model", (bad < 0) ? 0 : out_el(bad),
                (bad < 0) ? 0 : m_out[bad]);
         end
      end
   end

   task automatic pack_vec();
      for (int c = 0; c < COLS; c++) vec_in[c*EW +: EW] = 16'(vx[c]);
   endtask

   task automatic load_w(int nr);
      for (int r = 0; r < nr; r++)
         for (int b = 0; b < BEATS; b++) begin
            wt_we = 1'b1;
            wt_waddr = 10'(r * BEATS + b);
            for (int k = 0; k < L; k++) wt_wdata[k*EW +: EW] = 16'(mW[r][b*L + k]);
            @(negedge clk);
         end
      wt_we = 1'b0;
   endtask

   task automatic clear_all();
      for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) mW[r][c] = 0;
      for (int c = 0; c < COLS; c++) vx[c] = 0;
   endtask

   // one run; poke_at > 0 raises a conflicting start at that cycle of the run
   task automatic run(int nr, int nc, string req, int poke_at);
      int n = 0;
      pack_vec();
      rows_m1 = 6'(nr - 1);
      cols_m1 = 6'(nc - 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) begin
         if (poke_at > 0 && n == poke_at) begin
            start = 1'b1; rows_m1 = 6'd1; cols_m1 = 6'd2;
            for (int c = 0; c < COLS; c++) vec_in[c*EW +: EW] = 16'($urandom);
         end else start = 1'b0;
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      chk(n == nr * ((nc + L - 1) / L) + 1, "R7", "latency", n, nr * ((nc + L - 1) / L) + 1);
      for (int r = 0; r < ROWS; r++)
         chk(out_el(r) == ((r < nr) ? expect_row(r, nc) : 0), (r < nr) ? req : "R9",
             $sformatf("row %0d", r), out_el(r), (r < nr) ? expect_row(r, nc) : 0);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      begin
         int nz = 0;
         for (int r = 0; r < ROWS; r++) if (out_el(r) != 0) nz++;
         chk(!busy && !done && nz == 0, "R1", "reset state nonzero rows", nz, 0);
      end
      mon_on = 1;

      // R2: identity-like weights 1.0, plus a scaled row; layout and formats
      clear_all();
      for (int i = 0; i < 4; i++) vx[i] = (i + 1) * 1000 - 2500;
      mW[0][0] = 16384; mW[1][1] = 16384; mW[2][3] = -8192; mW[2][2] = 16384;
      load_w(3);
      run(3, 4, "R2", 0);

      // R6: 6 columns, non-zero weights and vector past the last column
      clear_all();
      for (int r = 0; r < 5; r++) for (int c = 0; c < COLS; c++)
         mW[r][c] = int'($urandom_range(8191)) - 4096;
      for (int c = 0; c < COLS; c++) vx[c] = int'($urandom_range(16383)) - 8192;
      load_w(5);
      run(5, 6, "R6", 0);

      // R3: large partial sums cancel; R5: saturate at both rails
      clear_all();
      for (int c = 0; c < 8; c++) vx[c] = 32767;
      for (int c = 0; c < 4; c++) begin mW[0][c] = 32767; mW[0][c+4] = -32767; end
      mW[0][7] = -32766;
      for (int c = 0; c < 8; c++) begin mW[1][c] = 32767; mW[2][c] = -32768; end
      load_w(3);
      run(3, 8, "R3", 0);
      chk(out_el(0) == 2, "R3", "cancelled wide sum", out_el(0), 2);
      chk(out_el(1) == 32767, "R5", "positive clamp", out_el(1), 32767);
      chk(out_el(2) == -32768, "R5", "negative clamp", out_el(2), -32768);

      // R4: half-LSB rounding, one and two columns
      clear_all();
      vx[0] = 8192; vx[1] = 8191;
      mW[0][0] = 1; mW[1][0] = -1; mW[2][0] = 3; mW[3][0] = -3;
      mW[4][1] = 1; mW[5][1] = 2;
      load_w(6);
      run(6, 2, "R4", 0);
      chk(out_el(0) == 1, "R4", "+0.5 rounds up", out_el(0), 1);
      chk(out_el(1) == 0, "R4", "-0.5 rounds up", out_el(1), 0);
      chk(out_el(2) == 2, "R4", "+1.5 rounds up", out_el(2), 2);
      chk(out_el(3) == -1, "R4", "-1.5 rounds up", out_el(3), -1);
      chk(out_el(4) == 0, "R4", "below half", out_el(4), 0);
      chk(out_el(5) == 1, "R4", "above half", out_el(5), 1);

      // R11 and R10: full 64x64, with a start pulse mid-run
      clear_all();
      for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++)
         mW[r][c] = int'($urandom_range(4095)) - 2048;
      for (int c = 0; c < COLS; c++) vx[c] = int'($urandom_range(4095)) - 2048;
      load_w(ROWS);
      run(64, 64, "R11", 100);
      chk(out_el(63) == expect_row(63, 64), "R10", "result after ignored start",
          out_el(63), expect_row(63, 64));

      // R9: idle with changing inputs; outputs hold
      for (int i = 0; i < 6; i++) begin
         rows_m1 = 6'($urandom); cols_m1 = 6'($urandom);
         for (int c = 0; c < COLS; c++) vec_in[c*EW +: EW] = 16'($urandom);
         @(negedge clk);
      end
      chk(out_el(10) == expect_row(10, 64), "R9", "hold while idle", out_el(10), expect_row(10, 64));

      // R9: smaller run clears stale rows; R7: odd shape latency
      run(2, 13, "R9", 0);
      run(1, 1, "R7", 0);

      repeat (3) @(negedge clk);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule